// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the programmable state of a four-channel DMA controller: for each channel a base address, a base count, a working address and a transferred count. A host reaches the registers through a small port window. Byte-wide accesses go through a single shared byte pointer that alternates between the low and high half of whichever 16-bit register is addressed, so a full register takes two consecutive byte accesses. A word-wide write loads a whole base register at once.

Completing a write, either by the high byte or by a word-wide write, reinitialises the channel: the working address takes the base address and the transferred count returns to zero. The transfer engine reports progress by loading a channel's transferred count. Reads return the live address (working address plus transferred count) or the remaining count (base count minus transferred count). A build parameter selects a word controller variant. In that variant the ports are spaced two apart and internal address and count values are the base doubled, and readback halves them again.

Top module: `dma_chan_regfile`

## Requirements
- R1: After a synchronous reset every base, working and transferred value is zero and the byte pointer `byte_hi` is 0, so every readback byte is 0x00.
- R2: Each byte-wide access flips `byte_hi`. A read with `acc_wr` low counts as one, and so does a write with `acc_wide` low. The access goes to the low byte when `byte_hi` is 0 and to the high byte when it is 1, whichever channel or register it addresses.
- R3: A byte write with `byte_hi` = 0 replaces bits 7:0 of the addressed base register with `acc_wdata[7:0]`. It leaves bits 15:8, the working address and the transferred count unchanged.
- R4: A byte write with `byte_hi` = 1 replaces bits 15:8 with `acc_wdata[7:0]`. It then reinitialises the channel: the working address becomes the base address scaled by the controller, and the transferred count becomes 0.
- R5: A write with `acc_wide` = 1 loads all 16 bits of `acc_wdata` into the addressed base register and reinitialises the channel. It leaves `byte_hi` unchanged.
- R6: With `WORD_MODE` = 0, `acc_off[0]` selects address (0) or count (1) and `acc_off[2:1]` selects the channel.
- R7: With `WORD_MODE` = 1, `acc_off[1]` selects address (0) or count (1) and `acc_off[3:2]` selects the channel. Internal address and count values are the base shifted left by one, in 17 bits.
- R8: Address readback is the value (working address + transferred count), taken modulo the internal width.
- R9: Count readback is the value (scaled base count − transferred count), taken modulo the internal width.
- R10: `acc_rdata` is the readback value shifted right by the scale (0 or 1). It gives bits 7:0 when `byte_hi` = 0 and bits 15:8 when `byte_hi` = 1. It is combinational during the read cycle.
- R11: `ptr_clear` or `master_clear` forces `byte_hi` to 0 at the next edge. This takes priority over an access in the same cycle.
- R12: `xfer_load[i]` loads `xfer_count` into channel i's transferred count. Other channels keep theirs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_wide | input | 1 | Write is 16 bits wide |
| acc_off | input | 4 | Port offset within the window |
| acc_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| acc_rdata | output | 8 | Readback byte |
| ptr_clear | input | 1 | Clear byte pointer command |
| master_clear | input | 1 | Master clear command |
| xfer_load | input | 4 | Per-channel transferred-count load strobe |
| xfer_count | input | 16 | Transferred-count value |
| byte_hi | output | 1 | Byte pointer state |

## Verification
If the byte pointer holds the wrong value, `byte_hi` shows it one cycle after the access. The next byte read also comes back with its halves swapped. A missed or extra reinitialisation shows on the very next address read: the readback is offset by the old transferred count, or it is missing the newly written base. A wrong decode or wrong scaling shows when another channel's data comes back. In the word variant it shows as a value off by a factor of two, visible as soon as a full two-byte readback completes.

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile #(
  parameter bit WORD_MODE = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_wr,
  input  logic        acc_rd,
  input  logic        acc_wide,
  input  logic [3:0]  acc_off,
  input  logic [15:0] acc_wdata,
  output logic [7:0]  acc_rdata,
  input  logic        ptr_clear,
  input  logic        master_clear,
  input  logic [3:0]  xfer_load,
  input  logic [15:0] xfer_count,
  output logic        byte_hi
);
  localparam int S   = WORD_MODE ? 1 : 0;
  localparam int DW  = 16;
  localparam int IW  = DW + S;
  localparam int NCH = 4;
  localparam int CW  = $clog2(NCH);

  logic [CW-1:0] sel_ch;
  logic          sel_cnt;

  generate
    if (WORD_MODE) begin : g_word
      assign sel_cnt = acc_off[1];
      assign sel_ch  = acc_off[3:2];
    end else begin : g_byte
      assign sel_cnt = acc_off[0];
      assign sel_ch  = acc_off[2:1];
    end
  endgenerate

  logic [DW-1:0] base_a [NCH];
  logic [DW-1:0] base_c [NCH];
  logic [IW-1:0] cur_a  [NCH];
  logic [IW-1:0] done_q [NCH];
  logic          ptr_q;

  wire clr     = ptr_clear | master_clear;
  wire wr_byte = acc_wr & ~acc_wide;
  wire wr_word = acc_wr & acc_wide;
  wire rd_byte = acc_rd & ~acc_wr;
  wire step    = wr_byte | rd_byte;
  wire reload  = wr_word | (wr_byte & ptr_q);

  logic [DW-1:0] new_base;
  always_comb begin
    new_base = sel_cnt ? base_c[sel_ch] : base_a[sel_ch];
    if (wr_word)    new_base = acc_wdata;
    else if (ptr_q) new_base[15:8] = acc_wdata[7:0];
    else            new_base[7:0]  = acc_wdata[7:0];
  end

  logic [IW-1:0] reload_addr;
  assign reload_addr = IW'(sel_cnt ? base_a[sel_ch] : new_base) << S;

  always_ff @(posedge clk) begin
    if (rst)                ptr_q <= 1'b0;
    else if (clr)           ptr_q <= 1'b0;
    else if (step)          ptr_q <= ~ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0;
        base_c[i] <= '0;
        cur_a[i]  <= '0;
        done_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (acc_wr && sel_ch == CW'(i)) begin
          if (sel_cnt) base_c[i] <= new_base;
          else         base_a[i] <= new_base;
        end
        if (reload && sel_ch == CW'(i)) begin
          cur_a[i]  <= reload_addr;
          done_q[i] <= '0;
        end else if (xfer_load[i]) begin
          done_q[i] <= IW'(xfer_count);
        end
      end
    end
  end

  logic [IW-1:0] rb_full;
  logic [DW-1:0] rb_val;
  assign rb_full   = sel_cnt ? ((IW'(base_c[sel_ch]) << S) - done_q[sel_ch])
                             : (cur_a[sel_ch] + done_q[sel_ch]);
  assign rb_val    = DW'(rb_full >> S);
  assign acc_rdata = ptr_q ? rb_val[15:8] : rb_val[7:0];
  assign byte_hi   = ptr_q;

  a_r2_toggle: assert property (@(posedge clk) disable iff (rst)
    step && !clr |=> byte_hi != $past(byte_hi));
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !byte_hi);
  a_r5_wide_hold: assert property (@(posedge clk) disable iff (rst)
    wr_word && !clr |=> $stable(byte_hi));

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chk
      a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        reload && sel_ch == CW'(g) |=> done_q[g] == '0 && cur_a[g] == (IW'(base_a[g]) << S));
      a_r3_low_keep: assert property (@(posedge clk) disable iff (rst)
        wr_byte && !byte_hi && sel_ch == CW'(g)
        |=> $stable(base_a[g][15:8]) && $stable(base_c[g][15:8]) && $stable(cur_a[g]));
      a_r12_load: assert property (@(posedge clk) disable iff (rst)
        xfer_load[g] && !(reload && sel_ch == CW'(g)) |=> done_q[g] == IW'($past(xfer_count)));
    end
  endgenerate
endmodule

// File: tb/dma_chan_regfile_test.sv
module dma_chan_regfile_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        wr [2];
  logic        rd [2];
  logic        wide [2];
  logic [3:0]  off [2];
  logic [15:0] wdat [2];
  logic [7:0]  rdv [2];
  logic        pclr [2];
  logic        mclr [2];
  logic [3:0]  xl [2];
  logic [15:0] xv [2];
  logic        bh [2];

  dma_chan_regfile #(.WORD_MODE(1'b0)) uut (
    .clk(clk), .rst(rst), .acc_wr(wr[0]), .acc_rd(rd[0]), .acc_wide(wide[0]),
    .acc_off(off[0]), .acc_wdata(wdat[0]), .acc_rdata(rdv[0]),
    .ptr_clear(pclr[0]), .master_clear(mclr[0]), .xfer_load(xl[0]),
    .xfer_count(xv[0]), .byte_hi(bh[0]));

  dma_chan_regfile #(.WORD_MODE(1'b1)) uut_w (
    .clk(clk), .rst(rst), .acc_wr(wr[1]), .acc_rd(rd[1]), .acc_wide(wide[1]),
    .acc_off(off[1]), .acc_wdata(wdat[1]), .acc_rdata(rdv[1]),
    .ptr_clear(pclr[1]), .master_clear(mclr[1]), .xfer_load(xl[1]),
    .xfer_count(xv[1]), .byte_hi(bh[1]));

  int ntot = 0;
  int nfail = 0;
  bit done = 0;

  int ma [2][4];
  int mc [2][4];
  int mcur [2][4];
  int mx [2][4];
  bit mptr [2];

  task automatic chk(string req, int act, int exp);
    ntot++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_rd(int w, int ch, bit isc, bit hi);
    int m = (1 << (16 + w)) - 1;
    int v;
    if (isc) v = ((mc[w][ch] << w) - mx[w][ch]) & m;
    else     v = (mcur[w][ch] + mx[w][ch]) & m;
    v = v >> w;
    return hi ? ((v >> 8) & 255) : (v & 255);
  endfunction

  task automatic op(int w, bit we, bit re, bit wd, int ch, bit isc, int d, output int r);
    @(negedge clk);
    wr[w] = we; rd[w] = re; wide[w] = wd; wdat[w] = d[15:0];
    off[w] = (w != 0) ? {ch[1:0], isc, 1'b0} : {1'b0, ch[1:0], isc};
    #2 r = int'(rdv[w]);
    @(posedge clk); #1;
    wr[w] = 0; rd[w] = 0; wide[w] = 0;
    if (we) begin
      if (wd) begin
        if (isc) mc[w][ch] = d & 16'hFFFF; else ma[w][ch] = d & 16'hFFFF;
        mcur[w][ch] = (ma[w][ch] << w); mx[w][ch] = 0;
      end else if (mptr[w]) begin
        if (isc) mc[w][ch] = (mc[w][ch] & 255) | ((d & 255) << 8);
        else     ma[w][ch] = (ma[w][ch] & 255) | ((d & 255) << 8);
        mcur[w][ch] = (ma[w][ch] << w); mx[w][ch] = 0;
        mptr[w] = 0;
      end else begin
        if (isc) mc[w][ch] = (mc[w][ch] & 16'hFF00) | (d & 255);
        else     ma[w][ch] = (ma[w][ch] & 16'hFF00) | (d & 255);
        mptr[w] = 1;
      end
    end else if (re) begin
      mptr[w] = !mptr[w];
    end
    chk("R2 pointer", int'(bh[w]), int'(mptr[w]));
  endtask

  task automatic wbyte(int w, int ch, bit isc, int d);
    int r;
    op(w, 1, 0, 0, ch, isc, d, r);
  endtask

  task automatic rcheck(string req, int w, int ch, bit isc);
    int r;
    int e = exp_rd(w, ch, isc, mptr[w]);
    op(w, 0, 1, 0, ch, isc, 0, r);
    chk(req, r, e);
  endtask

  task automatic clear(int w, bit master);
    @(negedge clk);
    if (master) mclr[w] = 1; else pclr[w] = 1;
    @(posedge clk); #1;
    mclr[w] = 0; pclr[w] = 0;
    mptr[w] = 0;
    chk("R11 clear", int'(bh[w]), 0);
  endtask

  task automatic xload(int w, int ch, int v);
    @(negedge clk);
    xl[w][ch] = 1'b1; xv[w] = v[15:0];
    @(posedge clk); #1;
    xl[w] = '0;
    mx[w][ch] = v & 16'hFFFF;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      ntot++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  initial begin
    int r;
    for (int w = 0; w < 2; w++) begin
      wr[w] = 0; rd[w] = 0; wide[w] = 0; off[w] = '0; wdat[w] = '0;
      pclr[w] = 0; mclr[w] = 0; xl[w] = '0; xv[w] = '0; mptr[w] = 0;
      for (int c = 0; c < 4; c++) begin
        ma[w][c] = 0; mc[w][c] = 0; mcur[w][c] = 0; mx[w][c] = 0;
      end
    end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    for (int w = 0; w < 2; w++) begin
      chk("R1 pointer after reset", int'(bh[w]), 0);
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 4; k++) rcheck("R1 reset readback", w, c, k[1]);
    end

    // R3 R4 R6 R7 R10: full decode sweep with two-byte writes
    for (int w = 0; w < 2; w++)
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 2; k++) begin
          int d = (32'hA5C3 ^ (c * 32'h1357) ^ (k * 32'h0F0F) ^ (w * 32'h2222)) & 16'hFFFF;
          clear(w, 0);
          wbyte(w, c, k[0], d & 255);
          clear(w, 0);
          rcheck("R3 low byte only", w, c, k[0]);
          rcheck("R3 high byte kept", w, c, k[0]);
          clear(w, 0);
          wbyte(w, c, k[0], d & 255);
          wbyte(w, c, k[0], d >> 8);
        end
    for (int w = 0; w < 2; w++)
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 2; k++) begin
          rcheck(w != 0 ? "R7 decode low" : "R6 decode low", w, c, k[0]);
          rcheck(w != 0 ? "R7 decode high" : "R6 decode high", w, c, k[0]);
        end

    // R8 R9 R10 R12: transferred counts, including wrap past zero
    for (int w = 0; w < 2; w++) begin
      for (int c = 0; c < 4; c++) xload(w, c, c * 32'h0111 + 32'h35 + w);
      xload(w, 3, 32'hFFF0);
      for (int c = 0; c < 4; c++) begin
        rcheck("R8 R12 address readback", w, c, 0);
        rcheck("R8 R12 address readback", w, c, 0);
        rcheck("R9 R12 count readback", w, c, 1);
        rcheck("R9 R12 count readback", w, c, 1);
      end
    end

    // R4: completing a write reinitialises the channel
    for (int w = 0; w < 2; w++) begin
      xload(w, 1, 32'h0222);
      clear(w, 0);
      wbyte(w, 1, 1, 32'h11);
      wbyte(w, 1, 1, 32'h40);
      rcheck("R4 reload address", w, 1, 0);
      rcheck("R4 reload address", w, 1, 0);
      rcheck("R4 reload count", w, 1, 1);
      rcheck("R4 reload count", w, 1, 1);
    end

    // R5: word-wide write keeps pointer and reloads
    for (int w = 0; w < 2; w++) begin
      xload(w, 2, 32'h0077);
      clear(w, 0);
      wbyte(w, 0, 0, 32'h99);
      op(w, 1, 0, 1, 2, 0, 32'hBEEF, r);
      chk("R5 pointer held", int'(bh[w]), 1);
      op(w, 1, 0, 1, 2, 1, 32'h1234, r);
      clear(w, 0);
      rcheck("R5 wide address", w, 2, 0);
      rcheck("R5 wide address", w, 2, 0);
      rcheck("R5 wide count", w, 2, 1);
      rcheck("R5 wide count", w, 2, 1);
    end

    // R11: master clear forces pointer low
    for (int w = 0; w < 2; w++) begin
      rcheck("R11 before master clear", w, 0, 0);
      chk("R2 pointer high", int'(bh[w]), 1);
      clear(w, 1);
      rcheck("R11 after master clear", w, 0, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule